// File: doc/BRIEF.md
# DMA Cycle Timing Controller

This block times the command strobes of DMA transfers on an AT-style expansion bus. It is set up through one 8-bit configuration register. The DMA clock is a clock enable derived from the bus clock, and it runs either at the full bus rate or at half of it. A change of rate is passed through a synchronizer and takes effect only at a half-rate period boundary. Because of this, the enable never stays low for two bus cycles in a row.

A transfer begins with a one-cycle start pulse that carries a width flag (8-bit or 16-bit). On the next DMA clock tick the block drives the active-low I/O-read strobe low. The active-low memory-read strobe goes low either in the same tick or one DMA clock later. Both strobes stay low for a base of two DMA clocks plus a wait-state count taken from the register field for that width. They are released together, and a one-cycle done pulse follows.

The sequencer moves through these states:

- `ST_IDLE`: waiting for a start pulse. On a start it latches the register and the width and goes to `ST_ARMED`.
- `ST_ARMED`: on a DMA tick it goes to `ST_LEAD` when the memory-read delay is enabled, otherwise to `ST_CMD`.
- `ST_LEAD`: the I/O-read strobe alone is low. On a tick it goes to `ST_CMD`.
- `ST_CMD`: both strobes are low. A tick with the counter at zero goes to `ST_DONE`.
- `ST_DONE`: both strobes are released and done is pulsed. It always returns to `ST_IDLE` on the next cycle.

Top module: `dma_strobe_timer`

## Requirements
- R1: After reset both strobes are high, `xfer_done` and `xfer_busy` are low, the register reads as zero, and `dclk_en` is high on every second bus cycle.
- R2: Register bit 0 selects the DMA clock. With 0, `dclk_en` is high on one bus cycle in two. With 1, it is high on every bus cycle.
- R3: A change of bit 0 is synchronized and applied only at a half-rate period boundary, so `dclk_en` is never low on two consecutive bus cycles.
- R4: For a 16-bit transfer (`xfer_wide`=1), field bits 5:4 = k give k+1 wait states. `ior_n` is then low for exactly k+3 DMA clock ticks.
- R5: For an 8-bit transfer (`xfer_wide`=0), field bits 3:2 = k give k+1 wait states. `ior_n` is then low for exactly k+3 DMA clock ticks.
- R6: With bit 1 = 0, `memr_n` falls one DMA clock after `ior_n` and is low one tick less than `ior_n`. With bit 1 = 1, both strobes fall in the same cycle.
- R7: Both strobes rise in the same bus cycle. `xfer_done` is high for exactly that one cycle.
- R8: Bits 7:6 have no effect on timing.
- R9: A register write made during a transfer does not change that transfer. It applies from the next start.
- R10: `xfer_busy` is high from the cycle after an accepted start until done. A start pulse while busy is ignored.
- R11: Strobes fall only in the bus cycle that follows a `dclk_en` tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Data written to the configuration register |
| cfg_rdata | output | 8 | Current register contents |
| xfer_start | input | 1 | One-cycle request to begin a transfer |
| xfer_wide | input | 1 | Width of the requested transfer, 1 = 16-bit |
| dclk_en | output | 1 | DMA clock enable |
| ior_n | output | 1 | I/O-read strobe, active low |
| memr_n | output | 1 | Memory-read strobe, active low |
| xfer_busy | output | 1 | A transfer is pending or running |
| xfer_done | output | 1 | One-cycle pulse when the strobes are released |

## Verification
A wrong count load or decrement changes the length of the low time on `ior_n`. That difference can be measured in DMA ticks as soon as the transfer ends, within at most twelve bus cycles. If the delay flag is latched wrongly, or the rate and phase state is wrong, the difference between `memr_n` and `ior_n` moves or the spacing of `dclk_en` changes. Either one shows within two bus cycles of the point where it goes wrong. A sequencer that takes a start while it is busy, or that picks up a register write in the middle of a transfer, shows the wrong strobe length on the transfer that follows.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int CFG_W      = 8;
    localparam int WS_W       = 2;
    localparam int BASE_TICKS = 2;
    localparam int MAX_TICKS  = BASE_TICKS + (1 << WS_W);
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LEAD,
        ST_CMD,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [WS_W-1:0] ws_wide;
        logic [WS_W-1:0] ws_narrow;
        logic            mem_same;
        logic            full_rate;
    } timing_cfg_t;

    function automatic logic [CNT_W-1:0] ticks_minus_one(input logic [WS_W-1:0] field);
        return CNT_W'(field) + CNT_W'(BASE_TICKS);
    endfunction

endpackage

// File: rtl/dst_cfg_reg.sv
module dst_cfg_reg
    import dst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output timing_cfg_t      fields
);

    logic [CFG_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= wr_data;
        end
    end

    assign rd_data          = reg_q;
    assign fields.ws_wide   = reg_q[5:4];
    assign fields.ws_narrow = reg_q[3:2];
    assign fields.mem_same  = reg_q[1];
    assign fields.full_rate = reg_q[0];

endmodule

// File: rtl/dst_rate_gen.sv
module dst_rate_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_full,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   phase_q;
    logic                   rate_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sel_full;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sel_full};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            rate_q  <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                rate_q <= sync_q[SYNC_STAGES-1];
            end
        end
    end

    assign tick = rate_q | phase_q;

endmodule

// File: rtl/dst_seq.sv
module dst_seq
    import dst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  logic        wide,
    input  timing_cfg_t cfg,
    output logic        ior_n,
    output logic        memr_n,
    output logic        busy,
    output logic        done
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic             same_q, same_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        same_d  = same_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    len_d   = ticks_minus_one(wide ? cfg.ws_wide : cfg.ws_narrow);
                    same_d  = cfg.mem_same;
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (tick) begin
                    cnt_d   = len_q;
                    state_d = same_q ? ST_CMD : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    cnt_d   = cnt_q - 1'b1;
                    state_d = ST_CMD;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            same_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
            same_q  <= same_d;
        end
    end

    always_comb begin
        ior_n  = 1'b1;
        memr_n = 1'b1;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ARMED: ;
            ST_LEAD:  ior_n = 1'b0;
            ST_CMD: begin
                ior_n  = 1'b0;
                memr_n = 1'b0;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_strobe_timer.sv
module dma_strobe_timer
    import dst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             xfer_start,
    input  logic             xfer_wide,
    output logic             dclk_en,
    output logic             ior_n,
    output logic             memr_n,
    output logic             xfer_busy,
    output logic             xfer_done
);

    timing_cfg_t cfg_fields;

    dst_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .fields  (cfg_fields)
    );

    dst_rate_gen #(.SYNC_STAGES(SYNC_STAGES)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_full (cfg_fields.full_rate),
        .tick     (dclk_en)
    );

    dst_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (dclk_en),
        .start  (xfer_start),
        .wide   (xfer_wide),
        .cfg    (cfg_fields),
        .ior_n  (ior_n),
        .memr_n (memr_n),
        .busy   (xfer_busy),
        .done   (xfer_done)
    );

endmodule

// File: rtl/dst_checker.sv
module dst_checker (
    input logic clk,
    input logic rst_n,
    input logic dclk_en,
    input logic ior_n,
    input logic memr_n,
    input logic xfer_busy,
    input logic xfer_done
);

    p_en_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_en |=> dclk_en);

    p_memr_inside_ior_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !memr_n |-> !ior_n);

    p_release_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ior_n) |-> $rose(memr_n));

    p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (ior_n && memr_n && $past(!ior_n)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    p_fall_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ior_n) |-> $past(dclk_en));

    p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ior_n || xfer_done) |-> xfer_busy);

endmodule

bind dma_strobe_timer dst_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dclk_en   (dclk_en),
    .ior_n     (ior_n),
    .memr_n    (memr_n),
    .xfer_busy (xfer_busy),
    .xfer_done (xfer_done)
);

// File: tb/dma_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module dma_strobe_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       xfer_start = 1'b0;
    logic       xfer_wide = 1'b0;
    logic       dclk_en, ior_n, memr_n, xfer_busy, xfer_done;

    int n_checks = 0;
    int n_fail   = 0;
    int gaps     = 0;
    logic prev_low = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;

    dma_strobe_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_start(xfer_start), .xfer_wide(xfer_wide),
        .dclk_en(dclk_en), .ior_n(ior_n), .memr_n(memr_n),
        .xfer_busy(xfer_busy), .xfer_done(xfer_done)
    );

    // vector: {cfg[7:0], wide, 3'b0, ior_ticks[3:0], memr_ticks[3:0]}
    localparam logic [19:0] VEC [9] = '{
        {8'h00, 1'b0, 3'b0, 4'd3, 4'd2},
        {8'h00, 1'b1, 3'b0, 4'd3, 4'd2},
        {8'h30, 1'b1, 3'b0, 4'd6, 4'd5},
        {8'h30, 1'b0, 3'b0, 4'd3, 4'd2},
        {8'h0B, 1'b0, 3'b0, 4'd5, 4'd5},
        {8'h0B, 1'b1, 3'b0, 4'd3, 4'd3},
        {8'hC1, 1'b0, 3'b0, 4'd3, 4'd2},
        {8'h27, 1'b1, 3'b0, 4'd5, 4'd5},
        {8'h16, 1'b0, 3'b0, 4'd4, 4'd4}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_low && !dclk_en) gaps++;
            prev_low <= !dclk_en;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start(input logic wide);
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_wide = wide;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic measure(output int ior_c, output int memr_c, output int ior_t,
                           output int memr_t, output int done_ok);
        ior_c = 0; memr_c = 0; ior_t = 0; memr_t = 0; done_ok = 0;
        for (int i = 0; i < 200; i++) begin
            if (!ior_n) begin ior_c++; if (dclk_en) ior_t++; end
            if (!memr_n) begin memr_c++; if (dclk_en) memr_t++; end
            if (xfer_done) begin
                done_ok = (ior_n && memr_n) ? 1 : 0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dclk_en) c++;
        end
    endtask

    initial begin
        int ic, mc, it, mt, dk, ec, mult;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(ior_n && memr_n, "R1 strobes idle", {ior_n, memr_n}, 3);
        check(!xfer_done && !xfer_busy, "R1 done/busy low", {xfer_done, xfer_busy}, 0);
        check(cfg_rdata == 8'h00, "R1 register zero", cfg_rdata, 0);
        count_en(20, ec);
        check(ec == 10, "R1 R2 half rate after reset", ec, 10);

        // table-driven transfers: R4 R5 R6 R7 R8
        foreach (VEC[k]) begin
            logic [7:0] c;
            c = VEC[k][19:12];
            write_cfg(c);
            idle(8);
            pulse_start(VEC[k][11]);
            measure(ic, mc, it, mt, dk);
            mult = c[0] ? 1 : 2;
            check(it == int'(VEC[k][7:4]), $sformatf("R4 R5 R8 ior ticks vec%0d", k), it, VEC[k][7:4]);
            check(mt == int'(VEC[k][3:0]), $sformatf("R6 memr ticks vec%0d", k), mt, VEC[k][3:0]);
            check(ic == mult * int'(VEC[k][7:4]), $sformatf("R2 ior bus cycles vec%0d", k), ic, mult * VEC[k][7:4]);
            check(mc == mult * int'(VEC[k][3:0]), $sformatf("R6 memr bus cycles vec%0d", k), mc, mult * VEC[k][3:0]);
            check(dk == 1, $sformatf("R7 done with strobes high vec%0d", k), dk, 1);
            @(negedge clk);
            check(!xfer_done, "R7 done one cycle", xfer_done, 0);
        end

        // R2 full rate
        write_cfg(8'h01);
        idle(8);
        count_en(20, ec);
        check(ec == 20, "R2 full rate", ec, 20);

        // R3 switching at varied phases
        for (int s = 0; s < 8; s++) begin
            write_cfg(8'h00 | 8'(s[0]));
            idle(s % 3);
        end
        write_cfg(8'h00);
        idle(8);
        count_en(20, ec);
        check(ec == 10, "R3 settles to half rate", ec, 10);
        check(gaps == 0, "R3 no double-low enable", gaps, 0);

        // R9 mid-transfer register write
        pulse_start(1'b0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'h0C;
        @(negedge clk);
        cfg_wr = 1'b0;
        measure(ic, mc, it, mt, dk);
        check(it == 3, "R9 running transfer keeps old length", it, 3);
        idle(2);
        pulse_start(1'b0);
        measure(ic, mc, it, mt, dk);
        check(it == 6, "R9 next transfer uses new length", it, 6);

        // R10 start while busy ignored
        write_cfg(8'h00);
        idle(4);
        pulse_start(1'b0);
        check(xfer_busy, "R10 busy after start", xfer_busy, 1);
        idle(2);
        pulse_start(1'b1);
        measure(ic, mc, it, mt, dk);
        idle(1);
        ic = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ior_n || xfer_busy) ic++;
        end
        check(ic == 0, "R10 second start ignored", ic, 0);

        // R11: strobe falls one cycle after a tick (half rate)
        pulse_start(1'b0);
        ec = 0;
        for (int i = 0; i < 20; i++) begin
            logic pe;
            pe = dclk_en;
            @(negedge clk);
            if (!ior_n) begin
                ec = pe ? 1 : 0;
                break;
            end
        end
        check(ec == 1, "R11 strobe fall follows tick", ec, 1);
        measure(ic, mc, it, mt, dk);

        finish_run();
    end

endmodule